// File: doc/BRIEF.md
# Two-PLL Lock Retry Sequencer

This block runs the bring-up routine that gets a pair of on-chip PLLs to lock once after power-up. A single start pulse launches a run. The block first saves the current clock-divider word and switches the dividers to a known run value. It then makes up to a programmable number of attempts. Each attempt turns both PLLs off and waits for them to go quiet, clears the sticky fault flags, writes a fixed safe configuration and turns both PLLs on. It then waits until each PLL shows either lock or a slip.

Each PLL that locked cleanly is then measured by an external frequency checker. The two checks share one request/acknowledge handshake and always run in PLL order. A PLL that slipped, that saw a global fault or that never settled is marked failed and is not measured. The run ends on the first clean attempt or when the attempt budget is used up. Both PLLs are then left off, the divider word is restored in two writes, and `done_o` pulses with a two-bit fail code.

Top module: `pll_lock_seq`

## Requirements
- R1: When a start arrives with a retry count of zero, `done_o` rises on the next cycle and `fail_o` is 0. No divider write, flag clear, configuration load or PLL enable occurs.
- R2: When a start arrives with a nonzero retry count, the block captures `clkdiv_cur_i`. It then issues two consecutive divider writes before the first attempt: the captured value ANDed with `KEEP_MASK`, followed by `RUN_VALUE`.
- R3: Each attempt begins with both enables low and waits until both valid inputs are low. If a valid input is still high after `DIS_LIMIT` cycles, the run aborts with no configuration load. In that case `fail_o` equals the valid bits still high.
- R4: `stat_clr_o` pulses once per attempt while both enables are low, after the disable wait and before the configuration load.
- R5: `cfg_load_o` pulses once per attempt while both enables are low, with `cfg_o` = {ref divider[19:14]=1, multiplier[13:6]=27, first output divider[5:3]=2, second output divider[2:0]=4}. Both bits of `pll_en_o` go high together on the next cycle.
- R6: The lock wait ends once every PLL shows valid or slip. Otherwise it ends after `WAIT_LIMIT` cycles, and each PLL that showed neither is marked failed.
- R7: A PLL whose slip input or `glb_fault_i` is high when the lock wait ends gets its fail bit set (bit 0 for PLL1, bit 1 for PLL2) and is not measured.
- R8: Measurements run for PLL1 (`fchk_sel_o`=0) before PLL2 (`fchk_sel_o`=1). `fchk_req_o` and `fchk_sel_o` hold until `fchk_ack_i`, both enables stay high meanwhile, and `fchk_bad_i`=1 with the acknowledge sets that PLL's fail bit.
- R9: Attempts stop after the first attempt with a zero code, or after the retry count of attempts. `fail_o` reports the code of the last attempt.
- R10: At the end of a run, both enables are low. Two divider writes follow: the captured value ANDed with `KEEP_MASK`, then the captured value. `done_o` rises after these writes and the enables stay low.
- R11: `done_o` is a single-cycle pulse, exactly one per run. `fail_o` holds between runs. A start during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| retry_max_i | input | CNT_W | Maximum number of attempts |
| clkdiv_cur_i | input | DIV_W | Current clock-divider word, captured at start |
| clkdiv_o | output | DIV_W | Divider word to write |
| clkdiv_we_o | output | 1 | Divider write strobe |
| pll_en_o | output | 2 | PLL enables, bit 0 = PLL1 |
| pll_valid_i | input | 2 | PLL clock-valid (lock) indications |
| pll_slip_i | input | 2 | Sticky PLL slip flags |
| glb_fault_i | input | 1 | Sticky global slip/fail status |
| stat_clr_o | output | 1 | Clear pulse for slip flags and global status |
| cfg_load_o | output | 1 | Configuration write strobe |
| cfg_o | output | 20 | Safe PLL configuration word |
| fchk_req_o | output | 1 | Frequency-check request |
| fchk_sel_o | output | 1 | PLL to measure (0 = PLL1, 1 = PLL2) |
| fchk_ack_i | input | 1 | Frequency-check completion |
| fchk_bad_i | input | 1 | Measured frequency out of range, valid with ack |
| done_o | output | 1 | End-of-run pulse |
| fail_o | output | 2 | Fail code, bit 0 = PLL1, bit 1 = PLL2 |

## Verification
The hardest case to reach is a run in which the attempts fail in different ways before the last one decides the result. Examples are a slip on one PLL while the other locks and gets measured, a global fault that suppresses both measurements, and a PLL that never settles and trips the wait timeout. A reactive PLL and checker model in the bench follows a per-attempt script of outcomes and lock delays, so directed scripts chain these cases in a fixed order. Seeded random scripts then mix them. A held-high valid input reaches the disable abort, and a start pulse injected mid-run covers the ignored-start case.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int NPLL = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SAVK,
        S_SAVR,
        S_DIS,
        S_CLR,
        S_LOAD,
        S_WAIT,
        S_CHK,
        S_DEC,
        S_FIN,
        S_RSTK,
        S_RSTF
    } seq_st_e;

    typedef enum logic [1:0] {
        DW_KEEP,
        DW_RUN,
        DW_FULL
    } divw_e;

    typedef struct packed {
        logic [5:0] refdiv;
        logic [7:0] mult;
        logic [2:0] odiv;
        logic [2:0] rdiv;
    } pll_cfg_t;

    localparam pll_cfg_t SAFE_CFG = '{refdiv: 6'd1, mult: 8'd27, odiv: 3'd2, rdiv: 3'd4};

    function automatic logic is_div_write(seq_st_e s);
        return (s == S_SAVK) || (s == S_SAVR) || (s == S_RSTK) || (s == S_RSTF);
    endfunction

    function automatic divw_e div_sel(seq_st_e s);
        case (s)
            S_SAVR:  return DW_RUN;
            S_RSTF:  return DW_FULL;
            default: return DW_KEEP;
        endcase
    endfunction

endpackage

// File: rtl/pls_settle_eval.sv
module pls_settle_eval #(
    parameter int N = 2
) (
    input  logic [N-1:0] valid_i,
    input  logic [N-1:0] slip_i,
    input  logic         glb_i,
    output logic [N-1:0] settled_o,
    output logic [N-1:0] early_bad_o
);
    for (genvar g = 0; g < N; g++) begin : g_pll
        assign settled_o[g]   = valid_i[g] | slip_i[g];
        assign early_bad_o[g] = slip_i[g] | glb_i;
    end
endmodule

// File: rtl/pls_wait_timer.sv
module pls_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {W{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/pls_div_keeper.sv
module pls_div_keeper
    import pls_pkg::*;
#(
    parameter int             DIV_W     = 20,
    parameter logic [DIV_W-1:0] KEEP_MASK = '0,
    parameter logic [DIV_W-1:0] RUN_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_i,
    input  logic [DIV_W-1:0] cur_i,
    input  divw_e            sel_i,
    output logic [DIV_W-1:0] val_o
);
    logic [DIV_W-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_q <= '0;
        end else if (save_i) begin
            saved_q <= cur_i;
        end
    end

    always_comb begin
        case (sel_i)
            DW_RUN:  val_o = RUN_VALUE;
            DW_FULL: val_o = saved_q;
            default: val_o = saved_q & KEEP_MASK;
        endcase
    end
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
    import pls_pkg::*;
#(
    parameter int               CNT_W      = 8,
    parameter int               DIV_W      = 20,
    parameter logic [DIV_W-1:0] KEEP_MASK  = 20'hF0100,
    parameter logic [DIV_W-1:0] RUN_VALUE  = 20'h00100,
    parameter int               WAIT_LIMIT = 2000,
    parameter int               DIS_LIMIT  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] retry_max_i,
    input  logic [DIV_W-1:0] clkdiv_cur_i,
    output logic [DIV_W-1:0] clkdiv_o,
    output logic             clkdiv_we_o,
    output logic [1:0]       pll_en_o,
    input  logic [1:0]       pll_valid_i,
    input  logic [1:0]       pll_slip_i,
    input  logic             glb_fault_i,
    output logic             stat_clr_o,
    output logic             cfg_load_o,
    output logic [19:0]      cfg_o,
    output logic             fchk_req_o,
    output logic             fchk_sel_o,
    input  logic             fchk_ack_i,
    input  logic             fchk_bad_i,
    output logic             done_o,
    output logic [1:0]       fail_o
);
    localparam int TMR_LIM = (WAIT_LIMIT > DIS_LIMIT) ? WAIT_LIMIT : DIS_LIMIT;
    localparam int TMR_W   = $clog2(TMR_LIM + 2);
    localparam logic [TMR_W-1:0] WAIT_END = TMR_W'(WAIT_LIMIT);
    localparam logic [TMR_W-1:0] DIS_END  = TMR_W'(DIS_LIMIT);

    seq_st_e          st;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] att_q;
    logic [1:0]       pre_q;
    logic [1:0]       res_q;
    logic [1:0]       fail_q;
    logic             idx_q;
    logic             done_q;

    logic             tmr_clr;
    logic [TMR_W-1:0] tmr;
    logic [1:0]       settled;
    logic [1:0]       early_bad;
    logic             save_en;
    divw_e            dsel;

    pls_settle_eval #(.N(NPLL)) settle_i (
        .valid_i     (pll_valid_i),
        .slip_i      (pll_slip_i),
        .glb_i       (glb_fault_i),
        .settled_o   (settled),
        .early_bad_o (early_bad)
    );

    pls_wait_timer #(.W(TMR_W)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    pls_div_keeper #(
        .DIV_W     (DIV_W),
        .KEEP_MASK (KEEP_MASK),
        .RUN_VALUE (RUN_VALUE)
    ) div_i (
        .clk    (clk),
        .rst    (rst),
        .save_i (save_en),
        .cur_i  (clkdiv_cur_i),
        .sel_i  (dsel),
        .val_o  (clkdiv_o)
    );

    always_comb begin
        save_en     = (st == S_IDLE) && start_i && (retry_max_i != '0);
        dsel        = div_sel(st);
        clkdiv_we_o = is_div_write(st);
        tmr_clr     = (st != S_DIS) && (st != S_WAIT);
        pll_en_o    = ((st == S_WAIT) || (st == S_CHK)) ? 2'b11 : 2'b00;
        stat_clr_o  = (st == S_CLR);
        cfg_load_o  = (st == S_LOAD);
        cfg_o       = SAFE_CFG;
        fchk_req_o  = (st == S_CHK) && !pre_q[idx_q];
        fchk_sel_o  = idx_q;
        done_o      = done_q;
        fail_o      = fail_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cap_q  <= '0;
            att_q  <= '0;
            pre_q  <= '0;
            res_q  <= '0;
            fail_q <= '0;
            idx_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_i) begin
                        if (retry_max_i == '0) begin
                            fail_q <= '0;
                            done_q <= 1'b1;
                        end else begin
                            cap_q <= retry_max_i;
                            att_q <= '0;
                            st    <= S_SAVK;
                        end
                    end
                end
                S_SAVK: st <= S_SAVR;
                S_SAVR: st <= S_DIS;
                S_DIS: begin
                    if (pll_valid_i == 2'b00) begin
                        st <= S_CLR;
                    end else if (tmr >= DIS_END) begin
                        fail_q <= pll_valid_i;
                        st     <= S_RSTK;
                    end
                end
                S_CLR: st <= S_LOAD;
                S_LOAD: begin
                    att_q <= att_q + 1'b1;
                    st    <= S_WAIT;
                end
                S_WAIT: begin
                    if (&settled) begin
                        pre_q <= early_bad;
                        idx_q <= 1'b0;
                        st    <= S_CHK;
                    end else if (tmr >= WAIT_END) begin
                        pre_q <= early_bad | ~settled;
                        idx_q <= 1'b0;
                        st    <= S_CHK;
                    end
                end
                S_CHK: begin
                    if (pre_q[idx_q] || fchk_ack_i) begin
                        res_q[idx_q] <= pre_q[idx_q] | fchk_bad_i;
                        if (idx_q) begin
                            st <= S_DEC;
                        end else begin
                            idx_q <= 1'b1;
                        end
                    end
                end
                S_DEC: begin
                    fail_q <= res_q;
                    if ((res_q == 2'b00) || (att_q == cap_q)) begin
                        st <= S_FIN;
                    end else begin
                        st <= S_DIS;
                    end
                end
                S_FIN:  st <= S_RSTK;
                S_RSTK: st <= S_RSTF;
                S_RSTF: begin
                    done_q <= 1'b1;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pls_chk.sv
module pls_chk
    import pls_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] retry_max_i,
    input logic [1:0]       pll_en_o,
    input logic             stat_clr_o,
    input logic             cfg_load_o,
    input logic             fchk_req_o,
    input logic             fchk_sel_o,
    input logic             fchk_ack_i,
    input logic             done_o,
    input logic [1:0]       fail_o,
    input seq_st_e          st
);
    logic [CNT_W:0]   loads_q;
    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loads_q <= '0;
            cap_q   <= '0;
        end else if (st == S_IDLE && start_i) begin
            loads_q <= '0;
            cap_q   <= retry_max_i;
        end else if (cfg_load_o) begin
            loads_q <= loads_q + 1'b1;
        end
    end

    assert_zero_retry_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && start_i && retry_max_i == '0) |=> (done_o && fail_o == 2'b00 && pll_en_o == 2'b00));

    assert_clr_while_off_R4: assert property (@(posedge clk) disable iff (rst)
        stat_clr_o |-> (pll_en_o == 2'b00));

    assert_load_while_off_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_load_o |-> (pll_en_o == 2'b00));

    assert_enable_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_load_o |=> (pll_en_o == 2'b11));

    assert_enables_paired_R5: assert property (@(posedge clk) disable iff (rst)
        (pll_en_o == 2'b00) || (pll_en_o == 2'b11));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (fchk_req_o && !fchk_ack_i) |=> (fchk_req_o && $stable(fchk_sel_o)));

    assert_req_running_R8: assert property (@(posedge clk) disable iff (rst)
        fchk_req_o |-> (pll_en_o == 2'b11));

    assert_attempt_cap_R9: assert property (@(posedge clk) disable iff (rst)
        loads_q <= {1'b0, cap_q});

    assert_off_at_done_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pll_en_o == 2'b00));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_fail_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !start_i) |=> $stable(fail_o));
endmodule

bind pll_lock_seq pls_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .retry_max_i (retry_max_i),
    .pll_en_o    (pll_en_o),
    .stat_clr_o  (stat_clr_o),
    .cfg_load_o  (cfg_load_o),
    .fchk_req_o  (fchk_req_o),
    .fchk_sel_o  (fchk_sel_o),
    .fchk_ack_i  (fchk_ack_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .st          (st)
);

// File: tb/pll_lock_seq_tb_top.sv
module pll_lock_seq_tb_top;
    localparam int          CNT_W = 8;
    localparam int          DIV_W = 20;
    localparam logic [19:0] KM    = 20'hF0100;
    localparam logic [19:0] RV    = 20'h00100;
    localparam int          WL    = 200;
    localparam int          DL    = 16;
    localparam logic [19:0] EXP_CFG = (20'd1 << 14) | (20'd27 << 6) | (20'd2 << 3) | 20'd4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] retry_max_i = '0;
    logic [DIV_W-1:0] clkdiv_cur_i = '0;
    logic [DIV_W-1:0] clkdiv_o;
    logic             clkdiv_we_o;
    logic [1:0]       pll_en_o;
    logic [1:0]       pll_valid_i = 2'b00;
    logic [1:0]       pll_slip_i = 2'b00;
    logic             glb_fault_i = 1'b0;
    logic             stat_clr_o;
    logic             cfg_load_o;
    logic [19:0]      cfg_o;
    logic             fchk_req_o;
    logic             fchk_sel_o;
    logic             fchk_ack_i = 1'b0;
    logic             fchk_bad_i = 1'b0;
    logic             done_o;
    logic [1:0]       fail_o;

    always #5 clk = ~clk;

    pll_lock_seq #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .KEEP_MASK(KM), .RUN_VALUE(RV),
        .WAIT_LIMIT(WL), .DIS_LIMIT(DL)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .retry_max_i(retry_max_i),
        .clkdiv_cur_i(clkdiv_cur_i), .clkdiv_o(clkdiv_o), .clkdiv_we_o(clkdiv_we_o),
        .pll_en_o(pll_en_o), .pll_valid_i(pll_valid_i), .pll_slip_i(pll_slip_i),
        .glb_fault_i(glb_fault_i), .stat_clr_o(stat_clr_o), .cfg_load_o(cfg_load_o),
        .cfg_o(cfg_o), .fchk_req_o(fchk_req_o), .fchk_sel_o(fchk_sel_o),
        .fchk_ack_i(fchk_ack_i), .fchk_bad_i(fchk_bad_i), .done_o(done_o), .fail_o(fail_o)
    );

    // scenario: outcome 0 good, 1 bad frequency, 2 slip, 3 never settles
    int   outc [8][2];
    int   dly  [8][2];
    bit   glbs [8];
    bit   badtab [8][2];
    logic [1:0] stuck = 2'b00;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // monitor state
    int cyc = 0, start_cyc = 0, done_cyc = 0;
    int loads = 0, acks = 0, nw = 0, dones = 0, cfg_bad = 0, order_bad = 0;
    int en_cyc = 0, fdly = 0, clr_bad = 0;
    logic [19:0] wr [4];
    logic [1:0]  en_at_done = 2'b00;
    bit seen1 [8];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (start_i) start_cyc = cyc;
            if (cfg_load_o) begin
                loads = loads + 1;
                if (cfg_o != EXP_CFG) cfg_bad = cfg_bad + 1;
            end
            if (stat_clr_o && pll_en_o != 2'b00) clr_bad = clr_bad + 1;
            if (clkdiv_we_o) begin
                if (nw < 4) wr[nw] = clkdiv_o;
                nw = nw + 1;
            end
            if (done_o) begin
                dones = dones + 1;
                done_cyc = cyc;
                en_at_done = pll_en_o;
            end
            begin : model
                int a;
                a = (loads > 0) ? ((loads - 1) % 8) : 0;
                if (pll_en_o == 2'b11) en_cyc = en_cyc + 1;
                else en_cyc = 0;
                if (stat_clr_o) begin
                    pll_slip_i = 2'b00;
                    glb_fault_i = 1'b0;
                end
                if (en_cyc == 1 && glbs[a]) glb_fault_i = 1'b1;
                for (int p = 0; p < 2; p++) begin
                    if (stuck[p]) pll_valid_i[p] = 1'b1;
                    else if (pll_en_o != 2'b11) pll_valid_i[p] = 1'b0;
                    else if (en_cyc >= dly[a][p] && outc[a][p] < 2) pll_valid_i[p] = 1'b1;
                    if (pll_en_o == 2'b11 && en_cyc >= dly[a][p] && outc[a][p] == 2)
                        pll_slip_i[p] = 1'b1;
                end
                if (fchk_ack_i) begin
                    fchk_ack_i = 1'b0;
                    fdly = 0;
                end else if (fchk_req_o) begin
                    fdly = fdly + 1;
                    if (fdly >= 3) begin
                        fchk_ack_i = 1'b1;
                        fchk_bad_i = badtab[a][fchk_sel_o];
                        acks = acks + 1;
                        if (fchk_sel_o) seen1[a] = 1;
                        else if (seen1[a]) order_bad = order_bad + 1;
                    end
                end else begin
                    fdly = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int att_code(input int a);
        int c = 0;
        for (int p = 0; p < 2; p++)
            if (outc[a][p] >= 2 || glbs[a] || outc[a][p] == 1) c = c | (1 << p);
        return c;
    endfunction

    function automatic int att_meas(input int a);
        int m = 0;
        for (int p = 0; p < 2; p++)
            if (outc[a][p] < 2 && !glbs[a]) m = m + 1;
        return m;
    endfunction

    task automatic clear_scn();
        for (int a = 0; a < 8; a++) begin
            glbs[a] = 0;
            seen1[a] = 0;
            for (int p = 0; p < 2; p++) begin
                outc[a][p] = 0;
                dly[a][p] = 4;
                badtab[a][p] = 0;
            end
        end
    endtask

    task automatic set_att(input int a, input int o0, input int o1, input bit g);
        outc[a][0] = o0;
        outc[a][1] = o1;
        glbs[a] = g;
        badtab[a][0] = (o0 == 1);
        badtab[a][1] = (o1 == 1);
    endtask

    task automatic run(input int retry, input logic [19:0] div, input bit poke);
        int guard;
        int exp_fail, exp_att, exp_meas;
        logic [19:0] ew [4];
        loads = 0; acks = 0; nw = 0; dones = 0; cfg_bad = 0; order_bad = 0; clr_bad = 0;
        for (int a = 0; a < 8; a++) seen1[a] = 0;
        @(posedge clk); #2;
        clkdiv_cur_i = div;
        retry_max_i = CNT_W'(retry);
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        if (poke) begin
            repeat (8) @(posedge clk);
            #2;
            retry_max_i = '0;
            start_i = 1'b1;
            @(posedge clk); #2;
            start_i = 1'b0;
            retry_max_i = CNT_W'(retry);
        end
        guard = 0;
        while (dones == 0 && guard < 20000) begin
            @(posedge clk);
            guard = guard + 1;
        end
        repeat (4) @(posedge clk);

        exp_fail = 0; exp_att = 0; exp_meas = 0;
        if (stuck != 2'b00 && retry != 0) begin
            exp_fail = stuck;
        end else begin
            for (int a = 0; a < retry; a++) begin
                exp_att = exp_att + 1;
                exp_meas = exp_meas + att_meas(a);
                exp_fail = att_code(a);
                if (exp_fail == 0) break;
            end
        end
        ew[0] = div & KM; ew[1] = RV; ew[2] = div & KM; ew[3] = div;

        check(dones == 1, "R11 one done per run", dones, 1);
        check(fail_o == 2'(exp_fail), "R9 fail code", fail_o, exp_fail);
        check(loads == exp_att, "R9 attempt count", loads, exp_att);
        check(acks == exp_meas, "R8 measurement count", acks, exp_meas);
        check(order_bad == 0, "R8 PLL1 measured first", order_bad, 0);
        check(cfg_bad == 0, "R5 configuration word", cfg_bad, 0);
        check(clr_bad == 0, "R4 clear while off", clr_bad, 0);
        check(en_at_done == 2'b00 && pll_en_o == 2'b00, "R10 PLLs off at end", pll_en_o, 0);
        if (retry == 0) begin
            check(nw == 0, "R1 no divider writes", nw, 0);
            check(done_cyc - start_cyc == 1, "R1 done latency", done_cyc - start_cyc, 1);
        end else begin
            check(nw == 4, "R2 divider write count", nw, 4);
            check(wr[0] == ew[0] && wr[1] == ew[1], "R2 divider save writes", wr[1], ew[1]);
            check(wr[2] == ew[2] && wr[3] == ew[3], "R10 divider restore writes", wr[3], ew[3]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        clear_scn();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(done_o == 0 && fail_o == 0, "R11 reset outputs", fail_o, 0);
        check(pll_en_o == 0 && !fchk_req_o && !clkdiv_we_o, "R10 reset enables", pll_en_o, 0);

        // R1: zero budget
        run(0, 20'h12345, 0);
        // clean first attempt
        set_att(0, 0, 0, 0);
        run(3, 20'hABCDE, 0);
        // R7: slip, global fault, bad frequency
        clear_scn();
        set_att(0, 2, 0, 0);
        set_att(1, 0, 0, 1);
        set_att(2, 1, 1, 0);
        run(3, 20'h0F1F1, 0);
        // R6: PLL2 never settles, then clean
        clear_scn();
        set_att(0, 0, 3, 0);
        set_att(1, 0, 0, 0);
        run(2, 20'h55555, 0);
        // R3: PLL2 valid stuck high during disable
        clear_scn();
        stuck = 2'b10;
        run(4, 20'h77777, 0);
        stuck = 2'b00;
        repeat (3) @(posedge clk);
        // R11: start during a run ignored
        clear_scn();
        set_att(0, 1, 0, 0);
        set_att(1, 0, 0, 0);
        run(2, 20'h3C3C3, 1);

        for (int r = 0; r < 25; r++) begin
            int rt;
            clear_scn();
            for (int a = 0; a < 8; a++) begin
                int o0, o1;
                o0 = $urandom % 10; o1 = $urandom % 10;
                o0 = (o0 < 4) ? 0 : (o0 < 6) ? 1 : (o0 < 9) ? 2 : 3;
                o1 = (o1 < 4) ? 0 : (o1 < 6) ? 1 : (o1 < 9) ? 2 : 3;
                set_att(a, o0, o1, ($urandom % 8) == 0);
                dly[a][0] = 3 + ($urandom % 15);
                dly[a][1] = 3 + ($urandom % 15);
            end
            rt = 1 + ($urandom % 5);
            run(rt, 20'($urandom), 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule